// File: doc/BRIEF.md
# Spare-Slot Hub Arbiter

This arbiter controls access to a shared memory port that several cores use in turn. A free-running ring of slots, one per core, gives every core a fixed and predictable access window. When the owner of the next slot does not request it, the slot can go to another core. That core must be requesting and must have opted in to borrowing. The borrowed grant is marked on a separate flag, so the rest of the system can tell lent accesses apart from owned ones.

Borrowers take turns through a rotating fairness pointer, so no single core can absorb all idle slots. The decision for a slot is made one clock ahead, from the requests present on the edge that opens the slot. Owned accesses therefore see no extra decision latency. Only owned grants have deterministic timing. Lent grants depend on what the other cores are doing. The memory datapath is not part of this block.

Top module: `sparesl_hub_arb`

## Requirements
- R1: While reset is held, `grant_o` is all zero and `borrowed_o` is low. The first clock edge after reset is released decides slot 0. Each later edge decides the next slot, and slot NUM_CORES-1 is followed by slot 0. Slot k belongs to core k (bit k of every vector).
- R2: If the owner of a slot has its request bit set on the edge that decides that slot, the owner receives the grant and `borrowed_o` stays low, whatever other cores request.
- R3: If the owner is not requesting, the slot goes to another core that has both its request bit and its borrow-enable bit set, and `borrowed_o` is high for that grant.
- R4: A core whose borrow-enable bit is low never receives a slot other than its own.
- R5: The fairness pointer resets to core 0. A lent slot goes to the first eligible core at or after the pointer, searching upward with wrap-around. After each lent grant the pointer moves to the core just past the winner. Owned and idle slots leave the pointer unchanged.
- R6: If neither the owner nor any eligible borrower is requesting, `grant_o` is all zero and `borrowed_o` is low.
- R7: The grant for a slot depends only on the inputs sampled on the edge that opens that slot. It is visible for that one clock and reflects no earlier or later request.
- R8: `grant_o` has at most one bit set. `borrowed_o` is high only when a bit is set and that bit is not the slot owner's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CORES | Per-core access request for the slot being decided |
| borrow_en_i | input | NUM_CORES | Per-core opt-in for receiving spare slots |
| grant_o | output | NUM_CORES | One-hot grant for the current slot, all zero when the slot is idle |
| borrowed_o | output | 1 | High when the current grant went to a core other than the slot owner |

## Verification
The hardest case to reach is fairness among several borrowers. The pointer only moves on lent grants, and a lent grant needs an idle owner together with eligible borrowers. Long phases hold a small set of cores requesting with borrowing enabled while all other owners stay silent. This makes the pointer step around the ring many times, and the bench compares how many lent grants each borrower received. Single-cycle request pulses and a pseudo-random phase place the owner's request bit exactly on, or just off, the deciding edge.

// File: rtl/sparesl_pkg.sv
package sparesl_pkg;

   // Outcome of one slot decision
   typedef enum logic [1:0] {
      GK_IDLE  = 2'd0,
      GK_OWNED = 2'd1,
      GK_LENT  = 2'd2
   } grant_kind_e;

endpackage

// File: rtl/sparesl_slot_ring.sv
module sparesl_slot_ring #(
   parameter int unsigned SLOTS = 16,
   localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic [IW-1:0] cur_o,
   output logic [IW-1:0] nxt_o
);

   localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

   always_comb begin
      nxt_o = (cur_o == LAST) ? '0 : cur_o + 1'b1;
   end

   // Reset parks on the last slot so the first decided slot is slot 0
   always_ff @(posedge clk_i) begin
      if (!rst_ni) cur_o <= LAST;
      else         cur_o <= nxt_o;
   end

   AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_o == LAST) |=> (cur_o == '0));                                  // R1
   AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_o != LAST) |=> (cur_o == $past(cur_o) + 1'b1));                 // R1

endmodule

// File: rtl/sparesl_rr_pick.sv
module sparesl_rr_pick #(
   parameter int unsigned N  = 16,
   parameter int unsigned IW = 4
) (
   input  logic [N-1:0]  cand_i,
   input  logic [IW-1:0] ptr_i,
   output logic          found_o,
   output logic [IW-1:0] win_o
);

   localparam bit POW2 = ((1 << IW) == N);

   generate
      if (POW2) begin : g_pow2
         // Index wraps through natural truncation
         always_comb begin
            logic [IW-1:0] idx;
            found_o = 1'b0;
            win_o   = '0;
            for (int off = 0; off < N; off++) begin
               idx = ptr_i + IW'(off);
               if (!found_o && cand_i[idx]) begin
                  found_o = 1'b1;
                  win_o   = idx;
               end
            end
         end
      end else begin : g_generic
         // Index wraps through compare and subtract
         always_comb begin
            logic [IW:0] sum;
            found_o = 1'b0;
            win_o   = '0;
            for (int off = 0; off < N; off++) begin
               sum = {1'b0, ptr_i} + (IW+1)'(off);
               if (sum >= (IW+1)'(N)) sum = sum - (IW+1)'(N);
               if (!found_o && cand_i[sum[IW-1:0]]) begin
                  found_o = 1'b1;
                  win_o   = sum[IW-1:0];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sparesl_hub_arb.sv
module sparesl_hub_arb #(
   parameter int unsigned NUM_CORES = 16
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_CORES-1:0] req_i,
   input  logic [NUM_CORES-1:0] borrow_en_i,
   output logic [NUM_CORES-1:0] grant_o,
   output logic                 borrowed_o
);
   import sparesl_pkg::*;

   localparam int unsigned IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam logic [IW-1:0] LAST = IW'(NUM_CORES - 1);

   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("sparesl_hub_arb: NUM_CORES must be at least 2");
      end
      if (NUM_CORES > 256) begin : g_bad_size
         $error("sparesl_hub_arb: NUM_CORES above 256 is not supported");
      end
   endgenerate

   logic [IW-1:0]        slot_q, slot_nxt;
   logic [IW-1:0]        ptr_q, win;
   logic                 found;
   logic [NUM_CORES-1:0] owner_oh, cand, grant_d, grant_q;
   grant_kind_e          kind_d, kind_q;

   sparesl_slot_ring #(.SLOTS(NUM_CORES)) i_ring (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_o  (slot_q),
      .nxt_o  (slot_nxt)
   );

   always_comb begin
      owner_oh = '0;
      owner_oh[slot_nxt] = 1'b1;
   end

   // The owner is never a borrowing candidate for its own slot
   assign cand = req_i & borrow_en_i & ~owner_oh;

   sparesl_rr_pick #(.N(NUM_CORES), .IW(IW)) i_pick (
      .cand_i  (cand),
      .ptr_i   (ptr_q),
      .found_o (found),
      .win_o   (win)
   );

   always_comb begin
      grant_d = '0;
      kind_d  = GK_IDLE;
      if (req_i[slot_nxt]) begin
         grant_d = owner_oh;
         kind_d  = GK_OWNED;
      end else if (found) begin
         grant_d[win] = 1'b1;
         kind_d       = GK_LENT;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         grant_q <= '0;
         kind_q  <= GK_IDLE;
         ptr_q   <= '0;
      end else begin
         grant_q <= grant_d;
         kind_q  <= kind_d;
         if (kind_d == GK_LENT) ptr_q <= (win == LAST) ? '0 : win + 1'b1;
      end
   end

   assign grant_o    = grant_q;
   assign borrowed_o = (kind_q == GK_LENT);

   AST_GRANT_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o));                                                   // R8
   AST_OWNER_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[slot_nxt] |=> (grant_o[slot_q] && !borrowed_o));                // R2
   AST_LENT_NOT_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      borrowed_o |-> ((grant_o != '0) && !grant_o[slot_q]));                // R3
   AST_LENT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      borrowed_o |-> ((grant_o & $past(borrow_en_i) & $past(req_i)) != '0)); // R4
   AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i == '0) |=> ((grant_o == '0) && !borrowed_o));                  // R6

endmodule

// File: tb/test_sparesl_hub_arb.sv
module test_sparesl_hub_arb;
   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] en = '0;
   logic [N-1:0] gnt;
   logic         brw;

   always #5 clk = ~clk;

   sparesl_hub_arb #(.NUM_CORES(N)) i_sparesl_hub_arb (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .borrow_en_i (en),
      .grant_o     (gnt),
      .borrowed_o  (brw)
   );

   typedef struct {
      logic [N-1:0] gnt;
      logic         brw;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int   m_slot = N - 1;
   int   m_ptr  = 0;
   int   n_chk  = 0;
   int   n_bad  = 0;
   int   fair_cnt [N];

   // Driver: applies one vector per clock and predicts the next grant
   task automatic apply(input logic [N-1:0] r, input logic [N-1:0] e, input string tag);
      exp_t x;
      logic [N-1:0] one;
      logic [N-1:0] cand;
      bit found;
      @(negedge clk);
      rst_n = 1'b1;
      req = r;
      en = e;
      one = 1;
      m_slot = (m_slot + 1) % N;
      x.tag = tag;
      x.gnt = '0;
      x.brw = 1'b0;
      if (r[m_slot]) begin
         x.gnt = one << m_slot;
      end else begin
         cand = r & e & ~(one << m_slot);
         found = 0;
         for (int off = 0; off < N; off++) begin
            int idx;
            idx = (m_ptr + off) % N;
            if (!found && cand[idx]) begin
               found = 1;
               x.gnt = one << idx;
               x.brw = 1'b1;
               m_ptr = (idx + 1) % N;
            end
         end
      end
      exp_q.push_back(x);
   endtask

   // Monitor: compares each produced grant against the predicted one
   initial begin
      for (int i = 0; i < N; i++) fair_cnt[i] = 0;
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_chk++;
            if (gnt !== x.gnt || brw !== x.brw) begin
               n_bad++;
               $display("FAIL %s: grant=%h borrowed=%b expected grant=%h borrowed=%b",
                        x.tag, gnt, brw, x.gnt, x.brw);
            end
            if (x.tag == "R5 fairness" && brw === 1'b1) begin
               for (int i = 0; i < N; i++) if (gnt[i]) fair_cnt[i]++;
            end
         end
      end
   end

   task automatic check_reset(input string tag);
      n_chk++;
      if (gnt !== '0 || brw !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: grant=%h borrowed=%b expected grant=0 borrowed=0", tag, gnt, brw);
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      // R1: reset state, with requests asserted and ignored
      req = '1;
      en = '1;
      repeat (3) @(negedge clk);
      check_reset("R1 reset hold");
      @(negedge clk);
      check_reset("R1 reset hold late");
      req = '0;
      en = '0;

      // R1/R2: every core requests; each slot goes to its owner from slot 0 on
      for (int i = 0; i < 2 * N; i++) apply('1, '0, "R2 all owners");
      for (int i = 0; i < N; i++) apply('1, '1, "R2 owners beat borrowers");
      // R6: nothing requested
      for (int i = 0; i < N; i++) apply('0, '1, "R6 idle ring");
      // R4: requesters without borrow enable get only their own slots
      for (int i = 0; i < N; i++) apply(16'h00F0, '0, "R4 no opt-in");
      // R3/R5: two borrowers share every idle slot
      for (int i = 0; i < 4 * N; i++) apply(16'h0028, 16'h0028, "R5 fairness");
      // R4: mixed enables
      for (int i = 0; i < 2 * N; i++) apply(16'h0F0F, 16'h0101, "R4 mixed opt-in");
      // R3: single borrower wins every idle slot
      for (int i = 0; i < N; i++) apply(16'h8000, 16'h8000, "R3 single borrower");
      // R7: one-cycle request pulses
      for (int i = 0; i < 2 * N; i++) begin
         logic [N-1:0] one;
         one = 1;
         apply((one << ((i * 7) % N)) | (one << ((i * 3 + 1) % N)), 16'hAAAA, "R7 pulses");
      end
      // R8/R3/R4: pseudo-random traffic
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         apply(lf[15:0] & lf[31:16], lf[23:8], "R8 random");
      end
      @(posedge clk);
      #4;

      // R5: both borrowers received lent slots in near-equal share
      n_chk++;
      if (fair_cnt[3] == 0 || fair_cnt[5] == 0 ||
          fair_cnt[3] - fair_cnt[5] > 1 || fair_cnt[5] - fair_cnt[3] > 1) begin
         n_bad++;
         $display("FAIL R5 share: core3=%0d core5=%0d expected equal within one",
                  fair_cnt[3], fair_cnt[5]);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule